// File: doc/BRIEF.md
# Interrupt Line Combiner with Re-Assert Gap

This block merges four internal interrupt sources (key event, overflow, logic block, general input) into one active-low interrupt line for a host. Each source comes in as a pending level with its own clear strobe and enable bit. The line is driven low while at least one enabled source is pending. Register decode and the generation of each source sit outside the block.

One configuration input, `pulse_mode`, sets what happens when software clears one of several pending enabled sources. With `pulse_mode` low the line stays low. With it high the line goes high for a fixed gap of `GAP_US` microseconds and then goes low again. An edge-triggered host therefore sees a fresh falling edge for the interrupts still waiting. The gap length in clock cycles comes from the `CLK_FREQ_HZ` parameter.

A three-state machine controls the line. The states are IDLE (line high, nothing pending), DRIVE (line low) and GAP (line high, timer running). The transitions are:
- IDLE→DRIVE when an enabled source remains pending.
- DRIVE→IDLE when no enabled source remains after this cycle's clears.
- DRIVE→GAP when `pulse_mode` is high, a clear hits a pending enabled source and another enabled source remains.
- GAP→DRIVE when the timer expires with an enabled source pending.
- GAP→IDLE when the timer expires with none pending.

Top module: `irq_combiner`

## Requirements
- R1: After reset `irq_n` is 1 and stays 1 until an enabled source is pending.
- R2: The sources map to bit positions in `src_pend`, `src_clr` and `src_en`: bit 0 is key event, bit 1 is overflow, bit 2 is logic, bit 3 is general input. When a bit of `src_pend & src_en` becomes 1 in cycle k, `irq_n` reads 0 from cycle k+1.
- R3: A pending source whose `src_en` bit is 0 never pulls `irq_n` low.
- R4: With `pulse_mode` = 0, clearing one of several pending enabled sources leaves `irq_n` at 0 without a break.
- R5: With `pulse_mode` = 1, clearing one pending enabled source while another enabled source stays pending drives `irq_n` to 1 in the next cycle. `irq_n` then goes back to 0.
- R6: Clearing the last pending enabled source drives `irq_n` to 1 in the next cycle with no later re-assertion, in either mode.
- R7: A source that becomes pending and enabled during the gap does not end the gap early. The line returns to 0 only when the gap is over.
- R8: A clear strobe on a source that is not pending, or not enabled, does not change `irq_n`.
- R9: The gap lasts exactly max(1, CLK_FREQ_HZ*GAP_US/1000000) cycles of `irq_n` = 1.
- R10: If no enabled source is pending when the gap ends, `irq_n` stays 1.
- R11: A further clear during the gap neither restarts nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pend | input | N_SRC | Pending level of each source |
| src_clr | input | N_SRC | One-cycle clear strobe of each source |
| src_en | input | N_SRC | Enable of each source |
| pulse_mode | input | 1 | 1: re-assert with a gap on a partial clear; 0: stay low |
| irq_n | output | 1 | Combined interrupt line, active low |

## Verification
The bench builds the block with `CLK_FREQ_HZ` = 200000 and `GAP_US` = 50, which gives a 10-cycle gap. A full gap, a source arriving in the middle of it, a clear landing inside it and its expiry all fit within a few dozen cycles. A short gap also makes an off-by-one error in its length a large fraction of the total, so a wrong count is easy to see. The per-cycle reference model covers both modes on the same timeline.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_DRIVE = 2'd1,
        LN_GAP   = 2'd2
    } line_state_e;

    // Gap length in clock cycles, never below one cycle (R9)
    function automatic int gap_cycles(input longint freq_hz, input longint gap_us);
        longint c;
        c = (freq_hz * gap_us) / 64'd1000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] clr,
    input  logic [N_SRC-1:0] en,
    output logic             hit_any,
    output logic             remain_any
);
    logic [N_SRC-1:0] active;
    logic [N_SRC-1:0] hit;
    logic [N_SRC-1:0] remain;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // Only enabled sources count (R3); a clear counts only on an active source (R8)
        assign active[i] = pend[i] & en[i];
        assign hit[i]    = clr[i] & active[i];
        assign remain[i] = active[i] & ~clr[i];
    end

    assign hit_any    = |hit;
    assign remain_any = |remain;

endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start) |=> (cnt_q <= LAST)); // R9

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic remain_any,
    input  logic hit_any,
    input  logic pulse_mode,
    input  logic gap_done,
    output logic gap_start,
    output logic gap_run,
    output logic irq_n
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: begin
                if (remain_any) state_d = LN_DRIVE;                        // R2
            end
            LN_DRIVE: begin
                if (!remain_any)                        state_d = LN_IDLE; // R6
                else if (pulse_mode && hit_any)         state_d = LN_GAP;  // R5
            end
            LN_GAP: begin
                if (gap_done) state_d = remain_any ? LN_DRIVE : LN_IDLE;   // R7, R10
            end
            default: state_d = LN_IDLE;
        endcase
    end

    always_comb begin
        irq_n     = (state_q != LN_DRIVE);
        gap_run   = (state_q == LN_GAP);
        gap_start = (state_q == LN_DRIVE) && (state_d == LN_GAP);
    end

    AST_GAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && pulse_mode && hit_any && remain_any) |=> irq_n); // R5

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !pulse_mode && remain_any) |=> !irq_n); // R4

    AST_NO_EARLY_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_run && !gap_done) |=> irq_n); // R7

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
    parameter int N_SRC       = 4,
    parameter int CLK_FREQ_HZ = 250_000_000,
    parameter int GAP_US      = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pend,
    input  logic [N_SRC-1:0] src_clr,
    input  logic [N_SRC-1:0] src_en,
    input  logic             pulse_mode,
    output logic             irq_n
);
    localparam int GAP_LEN = irq_pkg::gap_cycles(longint'(CLK_FREQ_HZ), longint'(GAP_US));

    logic hit_any, remain_any;
    logic gap_start, gap_run, gap_done;

    irq_qualify #(.N_SRC(N_SRC)) u_qualify (
        .pend       (src_pend),
        .clr        (src_clr),
        .en         (src_en),
        .hit_any    (hit_any),
        .remain_any (remain_any)
    );

    irq_gap_timer #(.LEN(GAP_LEN)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (gap_start),
        .run   (gap_run),
        .done  (gap_done)
    );

    irq_line_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .remain_any (remain_any),
        .hit_any    (hit_any),
        .pulse_mode (pulse_mode),
        .gap_done   (gap_done),
        .gap_start  (gap_start),
        .gap_run    (gap_run),
        .irq_n      (irq_n)
    );

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && ((src_pend & src_en) == '0)) |=> irq_n); // R3

    AST_STRAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && ((src_clr & src_pend & src_en) == '0) && ((src_pend & src_en) != '0))
        |=> !irq_n); // R8

endmodule

// File: tb/irq_combiner_bench.sv
module irq_combiner_bench;
    localparam int FREQ = 200_000;
    localparam int GUS  = 50;
    localparam int GAP  = 10;   // 200000*50/1e6

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pend = '0, clr = '0, en = '0;
    logic       mode = 1'b0;
    logic       irq_n;

    int checks = 0, failures = 0;
    bit done_flag = 0;
    string cur_req = "R1";

    // reference model state
    bit m_low;
    int m_gap;

    always #2 clk = ~clk;

    irq_combiner #(.N_SRC(4), .CLK_FREQ_HZ(FREQ), .GAP_US(GUS)) u_irq_combiner (
        .clk(clk), .rst_n(rst_n), .src_pend(pend), .src_clr(clr),
        .src_en(en), .pulse_mode(mode), .irq_n(irq_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_low = 0; m_gap = 0;
        end else begin
            logic [3:0] act, rem;
            bit hit;
            act = pend & en;
            rem = act & ~clr;
            hit = |(clr & act);
            if (m_gap > 0) begin
                m_gap = m_gap - 1;
                if (m_gap == 0) m_low = |rem;
            end else if (m_low) begin
                if (rem == 0) m_low = 0;
                else if (mode && hit) begin m_low = 0; m_gap = GAP; end
            end else begin
                m_low = |rem;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            checks++;
            if (irq_n !== !m_low) begin
                failures++;
                $display("FAIL model compare [%s] t=%0t irq_n actual=%b expected=%b",
                         cur_req, $time, irq_n, !m_low);
            end
        end
    end

    task automatic expect_line(input logic exp, input string req);
        checks++;
        if (irq_n !== exp) begin
            failures++;
            $display("FAIL %s irq_n actual=%b expected=%b", req, irq_n, exp);
        end
    endtask

    task automatic expect_int(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s value actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear(input logic [3:0] m);
        @(negedge clk); clr = m;
        @(negedge clk); clr = '0; pend = pend & ~m;
    endtask

    // clears, then counts cycles with irq_n high; optional source add / late clear
    task automatic run_gap(input logic [3:0] cm, input logic [3:0] add_m, input int add_at,
                           input logic [3:0] late_m, input int late_at, input int cap,
                           output int n);
        bit drop;
        drop = 0;
        pulse_clear(cm);
        n = 0;
        while (irq_n === 1'b1 && n < cap) begin
            n++;
            if (drop) begin clr = '0; pend = pend & ~late_m; drop = 0; end
            if (n == add_at) pend = pend | add_m;
            if (n == late_at) begin clr = late_m; drop = 1; end
            @(negedge clk);
        end
        if (drop) begin clr = '0; pend = pend & ~late_m; end
    endtask

    initial begin
        int n;
        step(3);
        expect_line(1'b1, "R1 in reset");
        rst_n = 1'b1;
        step(3);
        expect_line(1'b1, "R1 after reset");

        // R2: each source bit alone asserts one cycle later
        cur_req = "R2"; en = 4'hF;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk); pend = 4'(1 << b);
            @(negedge clk); expect_line(1'b0, "R2 source asserts");
            pulse_clear(4'(1 << b));
            expect_line(1'b1, "R6 last clear releases");
        end

        // R3: disabled source
        cur_req = "R3"; en = 4'b0111; pend = 4'b1000;
        step(4); expect_line(1'b1, "R3 masked source");
        en = 4'hF; step(1); expect_line(1'b0, "R3 enabling asserts");
        pulse_clear(4'b1000);

        // R4: level mode
        cur_req = "R4"; mode = 1'b0; pend = 4'b0101; step(2);
        pulse_clear(4'b0001);
        expect_line(1'b0, "R4 level hold");
        step(3); expect_line(1'b0, "R4 level hold later");

        // R6: clear of the last one
        cur_req = "R6"; pulse_clear(4'b0100);
        expect_line(1'b1, "R6 release");
        step(GAP + 3); expect_line(1'b1, "R6 no reassert");

        // R5/R9: pulse mode gap
        cur_req = "R5"; mode = 1'b1; pend = 4'b1010; step(2);
        run_gap(4'b0010, 4'b0, 0, 4'b0, 0, 40, n);
        expect_int(n, GAP, "R9 gap length");
        expect_line(1'b0, "R5 reassert");

        // R7: new source during gap
        cur_req = "R7"; pend = 4'b0101; step(2);
        run_gap(4'b0001, 4'b0010, 3, 4'b0, 0, 40, n);
        expect_int(n, GAP, "R7 gap not shortened");
        expect_line(1'b0, "R7 reassert at gap end");
        pulse_clear(4'b0110);  // remaining two cleared together
        expect_line(1'b1, "R6 all cleared");
        pend = 4'b0;

        // R10: last remaining cleared inside gap
        cur_req = "R10"; pend = 4'b0101; step(2);
        run_gap(4'b0001, 4'b0, 0, 4'b0100, 4, 30, n);
        expect_int(n, 30, "R10 stays high after gap");

        // R11: clear inside gap does not restart it
        cur_req = "R11"; pend = 4'b0111; step(2);
        run_gap(4'b0001, 4'b0, 0, 4'b0010, 4, 40, n);
        expect_int(n, GAP, "R11 gap not restarted");
        expect_line(1'b0, "R11 reassert");

        // R8: stray clears in both modes
        cur_req = "R8"; en = 4'b1111; pend = 4'b0100;
        @(negedge clk); clr = 4'b1001;
        @(negedge clk); clr = '0; expect_line(1'b0, "R8 stray clear pulse mode");
        step(GAP + 2); expect_line(1'b0, "R8 no gap after stray");
        en = 4'b1011; pend = 4'b1100; mode = 1'b1;
        @(negedge clk); clr = 4'b0100;
        @(negedge clk); clr = '0; pend = 4'b1000;
        expect_line(1'b0, "R8 clear of disabled source");
        mode = 1'b0;
        @(negedge clk); clr = 4'b0001;
        @(negedge clk); clr = '0; expect_line(1'b0, "R8 stray clear level mode");

        step(2);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            failures++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule